// File: doc/BRIEF.md
# CAN Transmit Bit Monitor

This block watches a CAN node while it sends. At each sample point it compares the bit the node put on the bus with the bit it reads back. It raises a one-clock error pulse when the two disagree in a way that counts as an error in the current frame phase. The pulses are meant to set bits in a sticky status register kept elsewhere. Bit timing, stuffing, frame sequencing and error counting are handled by other logic. Phase information reaches this block as plain level inputs.

The sample-point strobe works like a valid signal with no ready. The monitor always accepts a sample and cannot apply back-pressure, so every strobe is judged in the clock where it is high. Recessive is logic 1 and dominant is logic 0. Every output is registered, so a pulse appears exactly one clock after the strobe that caused it.

Top module: `can_tx_bit_monitor`

## Requirements
- R1: While `rst_n` is low, and in every clock after release until a qualifying sample is judged, all three error outputs are 0.
- R2: When a sample is judged with `tx_bit`=1 (recessive) and `rx_bit`=0 (dominant), outside arbitration, outside the ACK slot and outside a passive error flag, `bit1_err` is 1 in the following clock.
- R3: When a sample is judged with `tx_bit`=0 (dominant) and `rx_bit`=1 (recessive), `bit0_err` is 1 in the following clock, whatever the phase inputs are.
- R4: A recessive-sent, dominant-read sample taken while `in_arbitration`=1 gives no `bit1_err`.
- R5: A recessive-sent, dominant-read sample taken while `in_ack_slot`=1 gives no `bit1_err`.
- R6: A recessive-sent, dominant-read sample taken while `passive_err_flag`=1 gives no `bit1_err`.
- R7: A sample judged while `in_ack_slot`=1 with `rx_bit`=1 (no dominant acknowledge seen) makes `ack_err` 1 in the following clock. A dominant `rx_bit` in the ACK slot gives no `ack_err`.
- R8: A sample is judged only when `smp_strobe`=1 and `transmitting`=1. In any other clock, all error outputs are 0 in the following clock.
- R9: Each error output is high for exactly one clock per judged sample. A judged sample with matching bits and no missing acknowledge gives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_strobe | input | 1 | One-clock strobe at the bit sample point |
| tx_bit | input | 1 | Bit the node is driving (1 = recessive) |
| rx_bit | input | 1 | Bit sampled from the bus (1 = recessive) |
| transmitting | input | 1 | Node is the transmitter of the current frame |
| in_arbitration | input | 1 | Current bit belongs to the arbitration field |
| in_ack_slot | input | 1 | Current bit is the ACK slot |
| passive_err_flag | input | 1 | Node is sending a passive error flag |
| bit1_err | output | 1 | Pulse: recessive sent, dominant read |
| bit0_err | output | 1 | Pulse: dominant sent, recessive read |
| ack_err | output | 1 | Pulse: no dominant bit in the ACK slot |

## Verification
The only state is the output register stage. A wrong gating term or a stuck register shows at the ports one clock after the strobe that should or should not have produced a pulse. It also shows as a pulse that lasts into the next clock. The bench covers every combination of the seven judging inputs, so any mis-masked phase input or swapped bit polarity appears within that sweep. Pulse width is checked by following each strobe with an idle clock.

// File: rtl/canbm_pkg.sv
package canbm_pkg;
  localparam logic RECESSIVE = 1'b1;
  localparam logic DOMINANT  = 1'b0;

  typedef enum int unsigned {
    ERR_BIT1 = 0,
    ERR_BIT0 = 1,
    ERR_ACK  = 2
  } err_kind_e;

  localparam int unsigned N_ERR = 3;

  typedef struct packed {
    logic in_arb;
    logic in_ack;
    logic passive_flag;
  } phase_t;
endpackage

// File: rtl/canbm_qualify.sv
module canbm_qualify (
  input  logic smp_strobe,
  input  logic transmitting,
  output logic judge
);
  // a sample counts only at the sample point of a bit we are sending
  always_comb judge = smp_strobe & transmitting;
endmodule

// File: rtl/canbm_classify.sv
module canbm_classify
  import canbm_pkg::*;
(
  input  logic             judge,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  phase_t           phase,
  output logic [N_ERR-1:0] err_raw
);
  logic sent_rec_read_dom;
  logic sent_dom_read_rec;
  logic bit1_masked;

  always_comb begin
    sent_rec_read_dom = (tx_bit == RECESSIVE) && (rx_bit == DOMINANT);
    sent_dom_read_rec = (tx_bit == DOMINANT) && (rx_bit == RECESSIVE);
    // overwrite by a dominant bit is legal in these phases
    bit1_masked = phase.in_arb | phase.in_ack | phase.passive_flag;

    err_raw           = '0;
    err_raw[ERR_BIT1] = judge & sent_rec_read_dom & ~bit1_masked;
    err_raw[ERR_BIT0] = judge & sent_dom_read_rec;
    err_raw[ERR_ACK]  = judge & phase.in_ack & (rx_bit == RECESSIVE);
  end
endmodule

// File: rtl/canbm_pulse_reg.sv
module canbm_pulse_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= d[g];
    end

    // R9: a pulse is driven by the request of the previous clock only
    assert_pulse_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !d[g] |=> !q[g]);
  end
endmodule

// File: rtl/can_tx_bit_monitor.sv
module can_tx_bit_monitor
  import canbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_strobe,
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic transmitting,
  input  logic in_arbitration,
  input  logic in_ack_slot,
  input  logic passive_err_flag,
  output logic bit1_err,
  output logic bit0_err,
  output logic ack_err
);
  logic             judge;
  phase_t           phase;
  logic [N_ERR-1:0] err_raw;
  logic [N_ERR-1:0] err_q;

  always_comb begin
    phase.in_arb       = in_arbitration;
    phase.in_ack       = in_ack_slot;
    phase.passive_flag = passive_err_flag;
  end

  canbm_qualify u_qualify (
    .smp_strobe   (smp_strobe),
    .transmitting (transmitting),
    .judge        (judge)
  );

  canbm_classify u_classify (
    .judge   (judge),
    .tx_bit  (tx_bit),
    .rx_bit  (rx_bit),
    .phase   (phase),
    .err_raw (err_raw)
  );

  canbm_pulse_reg #(.WIDTH(N_ERR)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (err_raw),
    .q     (err_q)
  );

  assign bit1_err = err_q[ERR_BIT1];
  assign bit0_err = err_q[ERR_BIT0];
  assign ack_err  = err_q[ERR_ACK];

  assert_bit1_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && transmitting && tx_bit && !rx_bit &&
     !in_arbitration && !in_ack_slot && !passive_err_flag) |=> bit1_err);

  assert_bit0_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && transmitting && !tx_bit && rx_bit) |=> bit0_err);

  assert_bit_err_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit1_err && bit0_err));

  assert_arb_masks_bit1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_arbitration |=> !bit1_err);

  assert_ack_masks_bit1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack_slot |=> !bit1_err);

  assert_passive_masks_bit1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    passive_err_flag |=> !bit1_err);

  assert_ack_missing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && transmitting && in_ack_slot && rx_bit) |=> ack_err);

  assert_ack_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack_slot && !rx_bit) |=> !ack_err);

  assert_no_judge_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_strobe && transmitting) |=> !(bit1_err || bit0_err || ack_err));
endmodule

// File: tb/test_can_tx_bit_monitor.sv
module test_can_tx_bit_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_strobe = 0, tx_bit = 1, rx_bit = 1, transmitting = 0;
  logic in_arbitration = 0, in_ack_slot = 0, passive_err_flag = 0;
  logic bit1_err, bit0_err, ack_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [2:0] exp;   // {ack, bit0, bit1}
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  can_tx_bit_monitor i_can_tx_bit_monitor (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .transmitting(transmitting), .in_arbitration(in_arbitration),
    .in_ack_slot(in_ack_slot), .passive_err_flag(passive_err_flag),
    .bit1_err(bit1_err), .bit0_err(bit0_err), .ack_err(ack_err)
  );

  function automatic logic [2:0] expect_of(logic s, logic t, logic tx, logic rx,
                                           logic arb, logic ack, logic pef);
    logic [2:0] e = 3'b000;
    if (s && t) begin
      if (tx == 1'b0 && rx == 1'b1) e[1] = 1'b1;
      if (tx == 1'b1 && rx == 1'b0 && !(arb || ack || pef)) e[0] = 1'b1;
      if (ack && rx == 1'b1) e[2] = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(logic s, logic t, logic tx, logic rx, logic arb,
                       logic ack, logic pef, string tag);
    item_t it;
    @(negedge clk);
    smp_strobe = s; transmitting = t; tx_bit = tx; rx_bit = rx;
    in_arbitration = arb; in_ack_slot = ack; passive_err_flag = pef;
    it.exp = expect_of(s, t, tx, rx, arb, ack, pef);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(string tag);
    drive(0, 1, 1, 1, 0, 0, 0, tag);
  endtask

  // monitor: compares after each edge once the registered outputs settle
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it = sb.pop_front();
      logic [2:0] act = {ack_err, bit0_err, bit1_err};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: {ack,bit0,bit1} actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: outputs during reset, with qualifying stimulus applied
    smp_strobe = 1; transmitting = 1; tx_bit = 0; rx_bit = 1;
    repeat (3) @(negedge clk);
    checks++;
    if ({ack_err, bit0_err, bit1_err} !== 3'b000) begin
      fails++;
      $display("FAIL R1: actual=%b expected=000", {ack_err, bit0_err, bit1_err});
    end
    smp_strobe = 0;
    @(negedge clk); rst_n = 1;
    idle("R1"); idle("R1");

    // directed cases, each followed by an idle clock for pulse width (R9)
    drive(1, 1, 1, 0, 0, 0, 0, "R2"); idle("R9");
    drive(1, 1, 0, 1, 0, 0, 0, "R3"); idle("R9");
    drive(1, 1, 0, 1, 1, 0, 0, "R3"); idle("R9");
    drive(1, 1, 1, 0, 1, 0, 0, "R4"); idle("R4");
    drive(1, 1, 1, 0, 0, 1, 0, "R5"); idle("R5");
    drive(1, 1, 1, 0, 0, 0, 1, "R6"); idle("R6");
    drive(1, 1, 1, 1, 0, 1, 0, "R7"); idle("R9");
    drive(1, 1, 1, 0, 0, 1, 0, "R7");
    drive(0, 1, 0, 1, 0, 1, 0, "R8");
    drive(1, 0, 0, 1, 0, 1, 0, "R8");
    drive(1, 0, 1, 0, 0, 0, 0, "R8");
    drive(1, 1, 1, 1, 0, 0, 0, "R9");
    drive(1, 1, 0, 0, 0, 0, 0, "R9");
    // back-to-back strobes: one pulse per judged sample
    drive(1, 1, 1, 0, 0, 0, 0, "R2");
    drive(1, 1, 1, 0, 0, 0, 0, "R2");
    idle("R9");

    // full sweep of all input combinations
    for (int v = 0; v < 128; v++) begin
      drive(v[0], v[1], v[2], v[3], v[4], v[5], v[6], "R8");
      idle("R9");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule